// File: doc/BRIEF.md
# Counted Master Transfer Sequencer

This block drives a byte-oriented serial bus master from a small register file. Software programs a slave address, a transfer byte count and a control word. A start command in the control word makes the block ask an external bus engine for a start-with-address. After that it issues send-byte or receive-byte requests, moving bytes between the bus and two four-byte buffers, and it ends the transfer with a stop request. The engine answers each request with one response pulse that carries an acknowledge flag and, for receives, a data byte. Only one request is outstanding at a time.

There are two transfer modes. In counted mode every byte moved lowers a working count. When that count reaches zero, the block either issues a stop (when software asked for one) or reports access-ready and drops the master bit. In repeat mode the count is ignored: the block sends whatever is buffered, or fills the receive buffer, and it runs until software sets the stop bit. A missing acknowledge on a data byte halts the data flow and cancels any pending stop request. Slave-mode and 10-bit-address starts are refused. The divider and bus-timing registers are only stored.

Top module: `cmt_sequencer`

## Requirements
- R1: A write to the control register (address 0) keeps only the bits in mask 0xCF87, and the register reads back the kept value.
- R2: A start request (op code 0) is issued only when the control write has enable (bit 15), master (bit 10) and start (bit 0) set and 10-bit mode (bit 8) clear. It carries the stored slave address and a read flag equal to the inverse of bit 9, and the start bit then reads 0. A refused start issues nothing.
- R3: A missing acknowledge on the start sets status bit 1, clears the stop bit (bit 1) and issues no further request.
- R4: In counted mode, buffered bytes are sent (op code 1) in write order, and the count register (address 2) reads the working count, which is reloaded from the programmed count at start and lowered by one per byte.
- R5: In counted mode with the stop bit set, a zero working count issues a stop request (op code 3). On its response the stop bit clears, the working count reloads and busy (status bit 12) clears.
- R6: In counted mode with the stop bit clear, a zero working count sets access-ready (status bit 2), clears the master bit and issues no stop. A later stop bit then ends the transfer.
- R7: In counted transmit, transmit-ready (status bit 4) is set while the transmit buffer is empty and the count is nonzero, and it is cleared once the count reaches zero.
- R8: In repeat mode (control bit 2), the count is ignored. Transmit sends every buffered byte and then sets transmit-ready. Receive issues receive requests (op code 2) until the 4-byte buffer is full and then sets receive-ready (status bit 3). Setting the stop bit ends the transfer.
- R9: A missing acknowledge on a sent byte sets status bit 1 and clears the stop bit. No further byte is sent until software sets the stop bit, and setting it then issues a stop.
- R10: With no transfer in progress, writes to the data register (address 3) cause no bus request, and busy reads 0.
- R11: The slave (address 4) and own (address 5) address registers keep their low 10 bits. The divider (6), low-time (7) and high-time (8) registers keep 8 bits.
- R12: With the default parameters, clearing the enable bit changes no other register.
- R13: Received bytes read from the data register in arrival order. In counted receive, receive-ready is set while the buffer holds data and clears when it empties. Writing 1 to status bits 1 and 2 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive buffer at address 3) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_cmd_valid | output | 1 | One-cycle request pulse to the bus engine |
| bus_cmd_op | output | 2 | Request: 0 start, 1 send, 2 receive, 3 stop |
| bus_cmd_addr | output | 10 | Slave address for a start |
| bus_cmd_rd | output | 1 | Start direction, 1 = read |
| bus_cmd_byte | output | 8 | Byte to send |
| bus_rsp_valid | input | 1 | One-cycle response from the bus engine |
| bus_rsp_ack | input | 1 | Acknowledge received |
| bus_rsp_byte | input | 8 | Received byte |

## Verification
Counted transmit is swept over counts one to four, each with its own byte values, so the number of sends, their order, the stop and the count reload are all compared against arithmetic expectations. A mid-transfer count read separates decrement-per-byte from reload behaviour. Transmit and receive are each run in repeat mode with a count of zero, which counted mode would refuse to move, so any bytes that are moved show that the count is ignored there. A missing acknowledge on the start and on the second send separates the abort path from normal completion, and a no-stop counted run separates access-ready from stop issue.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_CNT  = 4'd2;
  localparam logic [3:0] A_DATA = 4'd3;
  localparam logic [3:0] A_SLV  = 4'd4;
  localparam logic [3:0] A_OWN  = 4'd5;
  localparam logic [3:0] A_DIV  = 4'd6;
  localparam logic [3:0] A_TLO  = 4'd7;
  localparam logic [3:0] A_THI  = 4'd8;

  localparam int CB_EN  = 15;
  localparam int CB_MST = 10;
  localparam int CB_TRX = 9;
  localparam int CB_XA  = 8;
  localparam int CB_RPT = 2;
  localparam int CB_STP = 1;
  localparam int CB_STT = 0;
  localparam logic [15:0] CTRL_KEEP = 16'hCF87;
endpackage

// File: rtl/cmt_byte_fifo.sv
module cmt_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_pop, do_push;

  assign do_pop  = pop && (lvl_q != '0);
  assign do_push = push && ((lvl_q != LW'(DEPTH)) || do_pop);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop) lvl_d = lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else if (flush) mem_q[i] <= '0;
      else if (do_push && (wp_q == PW'(i))) mem_q[i] <= push_data;
    end
  end

  assign head  = mem_q[rp_q];
  assign level = lvl_q;

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
endmodule

// File: rtl/cmt_cfg_regs.sv
module cmt_cfg_regs #(
  parameter int SA_W = 10,
  parameter int TM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  logic [3:0]      addr,
  input  logic [SA_W-1:0] wdata,
  output logic [SA_W-1:0] slave_addr,
  output logic [SA_W-1:0] own_addr,
  output logic [TM_W-1:0] divider,
  output logic [TM_W-1:0] t_low,
  output logic [TM_W-1:0] t_high
);
  import cmt_pkg::*;

  logic [SA_W-1:0] slv_d, own_d;
  logic [TM_W-1:0] div_d, tlo_d, thi_d;

  always_comb begin
    slv_d = slave_addr;
    own_d = own_addr;
    div_d = divider;
    tlo_d = t_low;
    thi_d = t_high;
    if (clr) begin
      slv_d = '0; own_d = '0; div_d = '0; tlo_d = '0; thi_d = '0;
    end else if (we) begin
      case (addr)
        A_SLV:   slv_d = wdata;
        A_OWN:   own_d = wdata;
        A_DIV:   div_d = wdata[TM_W-1:0];
        A_TLO:   tlo_d = wdata[TM_W-1:0];
        A_THI:   thi_d = wdata[TM_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_addr <= '0;
      own_addr   <= '0;
      divider    <= '0;
      t_low      <= '0;
      t_high     <= '0;
    end else begin
      slave_addr <= slv_d;
      own_addr   <= own_d;
      divider    <= div_d;
      t_low      <= tlo_d;
      t_high     <= thi_d;
    end
  end
endmodule

// File: rtl/cmt_seq_ctl.sv
module cmt_seq_ctl #(
  parameter int  CNT_W     = 16,
  parameter int  SA_W      = 10,
  parameter int  BUF_DEPTH = 4,
  parameter bit  LEGACY_RST = 1'b0,
  localparam int LW        = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [15:0]      wdata,
  input  logic [SA_W-1:0]  slave_addr,
  input  logic [LW-1:0]    tx_level,
  input  logic [7:0]       tx_head,
  input  logic [LW-1:0]    rx_level,
  input  logic             bus_rsp_valid,
  input  logic             bus_rsp_ack,
  output logic [15:0]      ctrl_o,
  output logic [15:0]      status_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tx_pop,
  output logic             tx_flush,
  output logic             rx_push,
  output logic             rx_flush,
  output logic             cfg_clr,
  output logic             bus_cmd_valid,
  output logic [1:0]       bus_cmd_op,
  output logic [SA_W-1:0]  bus_cmd_addr,
  output logic             bus_cmd_rd,
  output logic [7:0]       bus_cmd_byte
);
  import cmt_pkg::*;

  logic [15:0]      ctrl_q, ctrl_d;
  logic [CNT_W-1:0] prog_q, prog_d, work_q, work_d;
  logic             busy_q, busy_d, pend_q, pend_d, halt_q, halt_d;
  bus_op_e          pend_op_q, pend_op_d, cop_q, cop_d;
  logic             nack_q, nack_d, ardy_q, ardy_d, rrdy_q, rrdy_d, xrdy_q, xrdy_d;
  logic             cv_q, cv_d, crd_q, crd_d;
  logic [SA_W-1:0]  caddr_q, caddr_d;
  logic [7:0]       cbyte_q, cbyte_d;

  logic ctrl_wr, cnt_wr, stat_wr, data_wr;
  logic rpt, trx, stp, cnt_zero, live, issue_stop;

  assign ctrl_wr  = we && (addr == A_CTRL);
  assign cnt_wr   = we && (addr == A_CNT);
  assign stat_wr  = we && (addr == A_STAT);
  assign data_wr  = we && (addr == A_DATA);
  assign rpt      = ctrl_q[CB_RPT];
  assign trx      = ctrl_q[CB_TRX];
  assign stp      = ctrl_q[CB_STP];
  assign cnt_zero = (work_q == '0);
  assign live     = rpt || !cnt_zero;
  assign issue_stop = rpt ? stp : (stp && (cnt_zero || halt_q));

  always_comb begin
    ctrl_d = ctrl_q;  prog_d = prog_q;  work_d = work_q;
    busy_d = busy_q;  pend_d = pend_q;  halt_d = halt_q;
    pend_op_d = pend_op_q;
    nack_d = nack_q;  ardy_d = ardy_q;  rrdy_d = rrdy_q;  xrdy_d = xrdy_q;
    cv_d = 1'b0;  cop_d = cop_q;  crd_d = crd_q;
    caddr_d = caddr_q;  cbyte_d = cbyte_q;
    tx_pop = 1'b0;  tx_flush = 1'b0;  rx_push = 1'b0;  rx_flush = 1'b0;
    cfg_clr = 1'b0;

    if (rx_level == '0) rrdy_d = 1'b0;

    if (pend_q && bus_rsp_valid) begin
      pend_d = 1'b0;
      case (pend_op_q)
        OP_START: begin
          if (bus_rsp_ack) begin
            busy_d = 1'b1;
            work_d = prog_q;
            halt_d = 1'b0;
          end else begin
            nack_d = 1'b1;
            ctrl_d[CB_STP] = 1'b0;
          end
        end
        OP_SEND: begin
          tx_pop = 1'b1;
          if (!rpt && !cnt_zero) work_d = work_q - 1'b1;
          if (!bus_rsp_ack) begin
            nack_d = 1'b1;
            ctrl_d[CB_STP] = 1'b0;
            halt_d = 1'b1;
          end
        end
        OP_RECV: begin
          rx_push = 1'b1;
          if (!rpt && !cnt_zero) work_d = work_q - 1'b1;
        end
        default: begin
          busy_d = 1'b0;
          ctrl_d[CB_STP] = 1'b0;
          work_d = prog_q;
          tx_flush = 1'b1;
          halt_d = 1'b0;
        end
      endcase
    end else if (busy_q && !pend_q) begin
      if (issue_stop) begin
        cv_d = 1'b1; cop_d = OP_STOP; pend_d = 1'b1; pend_op_d = OP_STOP;
      end else if (!rpt && cnt_zero && !halt_q) begin
        ardy_d = 1'b1;
        ctrl_d[CB_MST] = 1'b0;
      end else if (!halt_q && live) begin
        if (trx) begin
          if (tx_level != '0) begin
            cv_d = 1'b1; cop_d = OP_SEND; cbyte_d = tx_head;
            pend_d = 1'b1; pend_op_d = OP_SEND;
          end else begin
            xrdy_d = 1'b1;
          end
        end else if (rx_level != LW'(BUF_DEPTH)) begin
          cv_d = 1'b1; cop_d = OP_RECV; pend_d = 1'b1; pend_op_d = OP_RECV;
        end
      end
      if (!rpt && trx && (cnt_zero || halt_q)) xrdy_d = 1'b0;
      if (!trx && (rpt ? (rx_level == LW'(BUF_DEPTH)) : (rx_level != '0)))
        rrdy_d = 1'b1;
    end

    if (data_wr) xrdy_d = 1'b0;
    if (cnt_wr)  prog_d = wdata[CNT_W-1:0];
    if (stat_wr) begin
      if (wdata[1]) nack_d = 1'b0;
      if (wdata[2]) ardy_d = 1'b0;
    end

    if (ctrl_wr) begin
      ctrl_d = wdata & CTRL_KEEP;
      if (!wdata[CB_EN]) begin
        cfg_clr = LEGACY_RST;
      end else if (wdata[CB_MST] && !wdata[CB_XA] && wdata[CB_STT] && !busy_q && !pend_q) begin
        ctrl_d[CB_STT] = 1'b0;
        cv_d = 1'b1; cop_d = OP_START; caddr_d = slave_addr; crd_d = !wdata[CB_TRX];
        pend_d = 1'b1; pend_op_d = OP_START;
        tx_flush = 1'b1; rx_flush = 1'b1;
      end
    end

    if (cfg_clr) begin
      ctrl_d = '0; prog_d = '0; work_d = '0; busy_d = 1'b0; pend_d = 1'b0;
      halt_d = 1'b0; nack_d = 1'b0; ardy_d = 1'b0; rrdy_d = 1'b0; xrdy_d = 1'b0;
      cv_d = 1'b0; tx_flush = 1'b1; rx_flush = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;  prog_q <= '0;  work_q <= '0;
      busy_q <= 1'b0;  pend_q <= 1'b0;  halt_q <= 1'b0;
      pend_op_q <= OP_START;  cop_q <= OP_START;
      nack_q <= 1'b0;  ardy_q <= 1'b0;  rrdy_q <= 1'b0;  xrdy_q <= 1'b0;
      cv_q <= 1'b0;  crd_q <= 1'b0;  caddr_q <= '0;  cbyte_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;  prog_q <= prog_d;  work_q <= work_d;
      busy_q <= busy_d;  pend_q <= pend_d;  halt_q <= halt_d;
      pend_op_q <= pend_op_d;  cop_q <= cop_d;
      nack_q <= nack_d;  ardy_q <= ardy_d;  rrdy_q <= rrdy_d;  xrdy_q <= xrdy_d;
      cv_q <= cv_d;  crd_q <= crd_d;  caddr_q <= caddr_d;  cbyte_q <= cbyte_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign count_o  = work_q;
  assign status_o = {3'b000, busy_q, 7'b0, xrdy_q, rrdy_q, ardy_q, nack_q, 1'b0};
  assign bus_cmd_valid = cv_q;
  assign bus_cmd_op    = cop_q;
  assign bus_cmd_addr  = caddr_q;
  assign bus_cmd_rd    = crd_q;
  assign bus_cmd_byte  = cbyte_q;

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q && cop_q == OP_START) |->
      $past(we && addr == A_CTRL && wdata[CB_EN] && wdata[CB_MST] && !wdata[CB_XA] && wdata[CB_STT]));

  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_q |=> !cv_q);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q && cop_q != OP_START) |-> $past(busy_q));

  // R9
  nack_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pend_op_q == OP_SEND && bus_rsp_valid && !bus_rsp_ack && !ctrl_wr)
      |=> (!ctrl_q[CB_STP] && halt_q));

  // R5
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pend_op_q == OP_STOP && bus_rsp_valid && !ctrl_wr)
      |=> (!busy_q && !ctrl_q[CB_STP]));
endmodule

// File: rtl/cmt_sequencer.sv
module cmt_sequencer #(
  parameter int CNT_W      = 16,
  parameter int SA_W       = 10,
  parameter int TM_W       = 8,
  parameter int BUF_DEPTH  = 4,
  parameter bit LEGACY_RST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        bus_cmd_valid,
  output logic [1:0]  bus_cmd_op,
  output logic [9:0]  bus_cmd_addr,
  output logic        bus_cmd_rd,
  output logic [7:0]  bus_cmd_byte,
  input  logic        bus_rsp_valid,
  input  logic        bus_rsp_ack,
  input  logic [7:0]  bus_rsp_byte
);
  import cmt_pkg::*;
  localparam int LW = $clog2(BUF_DEPTH + 1);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [15:0]      ctrl, status;
  logic [CNT_W-1:0] count;
  logic [SA_W-1:0]  slv, own, cmd_addr;
  logic [TM_W-1:0]  div, tlo, thi;
  logic [LW-1:0]    tx_level, rx_level;
  logic [7:0]       tx_head, rx_head;
  logic             tx_pop, tx_flush, rx_push, rx_flush, cfg_clr, rx_pop, tx_push;

  assign tx_push = reg_we && (reg_addr == A_DATA);
  assign rx_pop  = reg_re && (reg_addr == A_DATA);

  cmt_seq_ctl #(
    .CNT_W(CNT_W), .SA_W(SA_W), .BUF_DEPTH(BUF_DEPTH), .LEGACY_RST(LEGACY_RST)
  ) u_ctl (
    .clk(clk), .rst_n(rst_i_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .slave_addr(slv), .tx_level(tx_level), .tx_head(tx_head), .rx_level(rx_level),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_ack(bus_rsp_ack),
    .ctrl_o(ctrl), .status_o(status), .count_o(count),
    .tx_pop(tx_pop), .tx_flush(tx_flush), .rx_push(rx_push), .rx_flush(rx_flush),
    .cfg_clr(cfg_clr), .bus_cmd_valid(bus_cmd_valid), .bus_cmd_op(bus_cmd_op),
    .bus_cmd_addr(cmd_addr), .bus_cmd_rd(bus_cmd_rd), .bus_cmd_byte(bus_cmd_byte)
  );

  assign bus_cmd_addr = 10'(cmd_addr);

  cmt_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_txbuf (
    .clk(clk), .rst_n(rst_i_n), .flush(tx_flush), .push(tx_push),
    .push_data(reg_wdata[7:0]), .pop(tx_pop), .head(tx_head), .level(tx_level)
  );

  cmt_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_rxbuf (
    .clk(clk), .rst_n(rst_i_n), .flush(rx_flush), .push(rx_push),
    .push_data(bus_rsp_byte), .pop(rx_pop), .head(rx_head), .level(rx_level)
  );

  cmt_cfg_regs #(.SA_W(SA_W), .TM_W(TM_W)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .clr(cfg_clr), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[SA_W-1:0]), .slave_addr(slv), .own_addr(own),
    .divider(div), .t_low(tlo), .t_high(thi)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_STAT:  reg_rdata = status;
      A_CNT:   reg_rdata = 16'(count);
      A_DATA:  reg_rdata = 16'(rx_head);
      A_SLV:   reg_rdata = 16'(slv);
      A_OWN:   reg_rdata = 16'(own);
      A_DIV:   reg_rdata = 16'(div);
      A_TLO:   reg_rdata = 16'(tlo);
      A_THI:   reg_rdata = 16'(thi);
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: tb/cmt_sequencer_tb.sv
module cmt_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_cmd_valid, bus_cmd_rd;
  logic [1:0]  bus_cmd_op;
  logic [9:0]  bus_cmd_addr;
  logic [7:0]  bus_cmd_byte;
  logic        bus_rsp_valid = 1'b0, bus_rsp_ack = 1'b0;
  logic [7:0]  bus_rsp_byte = '0;

  int checks = 0, errors = 0;
  logic [1:0] lop [64];
  logic [7:0] lbyte [64];
  logic [9:0] laddr;
  logic       lrd;
  int nlog, send_idx, recv_idx, nack_send_at;
  bit nack_start;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd_op(bus_cmd_op), .bus_cmd_addr(bus_cmd_addr), .bus_cmd_rd(bus_cmd_rd),
    .bus_cmd_byte(bus_cmd_byte), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_ack(bus_rsp_ack), .bus_rsp_byte(bus_rsp_byte)
  );

  // bus engine model: answers each request three cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (bus_cmd_valid === 1'b1) begin
        if (nlog < 64) begin
          lop[nlog] = bus_cmd_op;
          lbyte[nlog] = bus_cmd_byte;
        end
        nlog++;
        bus_rsp_ack = 1'b1;
        case (bus_cmd_op)
          2'd0: begin laddr = bus_cmd_addr; lrd = bus_cmd_rd; bus_rsp_ack = !nack_start; end
          2'd1: begin bus_rsp_ack = (send_idx != nack_send_at); send_idx++; end
          2'd2: begin bus_rsp_byte = 8'hA0 + 8'(recv_idx); recv_idx++; end
          default: ;
        endcase
        repeat (2) @(negedge clk);
        bus_rsp_valid = 1'b1;
        @(negedge clk);
        bus_rsp_valid = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk);
    reg_addr = 4'd3; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic new_log();
    nlog = 0; send_idx = 0; recv_idx = 0; nack_send_at = -1; nack_start = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    new_log();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle(4);

    // reset state
    rd(4'd0, v); check("reset ctrl", v, 16'h0000);
    rd(4'd1, v); check("reset status", v, 16'h0000);
    rd(4'd2, v); check("reset count", v, 16'h0000);
    check("reset cmd_valid", 16'(bus_cmd_valid), 16'h0000);

    // R11 storage widths
    wr(4'd4, 16'hFD55); rd(4'd4, v); check("R11 slave", v, 16'h0155);
    wr(4'd5, 16'hFFFF); rd(4'd5, v); check("R11 own", v, 16'h03FF);
    wr(4'd6, 16'h01A5); rd(4'd6, v); check("R11 div", v, 16'h00A5);
    wr(4'd7, 16'h0F3C); rd(4'd7, v); check("R11 tlow", v, 16'h003C);
    wr(4'd8, 16'h1281); rd(4'd8, v); check("R11 thigh", v, 16'h0081);

    // R1 mask, R2 refused starts
    wr(4'd0, 16'hFFFF); settle(8);
    rd(4'd0, v); check("R1 ctrl mask", v, 16'hCF87);
    check("R2 xa refuse", 16'(nlog), 16'd0);
    wr(4'd0, 16'h8001); settle(8);
    rd(4'd0, v); check("R2 slave mode stored", v, 16'h8001);
    check("R2 slave refuse", 16'(nlog), 16'd0);
    // R12 disable keeps others
    wr(4'd0, 16'h0000);
    rd(4'd4, v); check("R12 slave kept", v, 16'h0155);
    rd(4'd8, v); check("R12 thigh kept", v, 16'h0081);

    // R10 data writes while idle
    wr(4'd3, 16'h0011); wr(4'd3, 16'h0022); settle(10);
    check("R10 no request", 16'(nlog), 16'd0);
    rd(4'd1, v); check("R10 busy clear", v & 16'h1000, 16'h0000);

    // R3 nack on start
    wr(4'd4, 16'h0055);
    new_log(); nack_start = 1;
    wr(4'd0, 16'h8603); settle(10);
    check("R3 one request", 16'(nlog), 16'd1);
    check("R2 start op", 16'(lop[0]), 16'd0);
    check("R2 start addr", 16'(laddr), 16'h0055);
    check("R2 start dir", 16'(lrd), 16'd0);
    rd(4'd1, v); check("R3 nack status", v, 16'h0002);
    rd(4'd0, v); check("R3 stop cleared", v, 16'h8600);
    wr(4'd1, 16'h0006); rd(4'd1, v); check("R13 w1c status", v, 16'h0000);

    // counted transmit sweep with stop: R4 R5 R7
    for (int n = 1; n <= 4; n++) begin
      new_log();
      wr(4'd2, 16'(n));
      wr(4'd0, 16'h8603); settle(10);
      rd(4'd1, v); check("R7 xrdy while empty", v & 16'h0010, 16'h0010);
      rd(4'd2, v); check("R4 count loaded", v, 16'(n));
      wr(4'd3, 16'(8'h10 * n));
      if (n > 1) begin
        settle(12);
        rd(4'd2, v); check("R4 count after one", v, 16'(n - 1));
      end
      for (int i = 1; i < n; i++) wr(4'd3, 16'(8'h10 * n + i));
      settle(40);
      check("R4 request total", 16'(nlog), 16'(n + 2));
      for (int i = 0; i < n; i++) begin
        check("R4 send op", 16'(lop[i + 1]), 16'd1);
        check("R4 send byte", 16'(lbyte[i + 1]), 16'(8'h10 * n + i));
      end
      check("R5 stop op", 16'(lop[n + 1]), 16'd3);
      rd(4'd0, v); check("R5 stop bit clear", v, 16'h8600);
      rd(4'd2, v); check("R5 count reload", v, 16'(n));
      rd(4'd1, v); check("R5 busy clear", v & 16'h1000, 16'h0000);
      check("R7 xrdy cleared at zero", v & 16'h0010, 16'h0000);
    end

    // R6 counted, no stop
    new_log();
    wr(4'd2, 16'd2);
    wr(4'd0, 16'h8601); settle(8);
    wr(4'd3, 16'h0031); wr(4'd3, 16'h0032); settle(30);
    check("R6 no stop issued", 16'(nlog), 16'd3);
    rd(4'd1, v); check("R6 ardy and busy", v & 16'h1004, 16'h1004);
    rd(4'd0, v); check("R6 master cleared", v, 16'h8200);
    wr(4'd0, 16'h8202); settle(12);
    check("R6 late stop", 16'(lop[3]), 16'd3);
    rd(4'd1, v); check("R6 busy clear", v & 16'h1000, 16'h0000);
    wr(4'd1, 16'h0006);

    // R9 nack on second send
    new_log(); nack_send_at = 1;
    wr(4'd2, 16'd3);
    wr(4'd0, 16'h8603); settle(8);
    wr(4'd3, 16'h0041); wr(4'd3, 16'h0042); wr(4'd3, 16'h0043); settle(30);
    check("R9 sends halted", 16'(nlog), 16'd3);
    rd(4'd1, v); check("R9 nack busy", v & 16'h1002, 16'h1002);
    rd(4'd0, v); check("R9 stop cleared", v & 16'h0002, 16'h0000);
    rd(4'd2, v); check("R9 count", v, 16'd1);
    wr(4'd0, 16'h8602); settle(12);
    check("R9 stop after halt", 16'(nlog), 16'd4);
    check("R9 stop op", 16'(lop[3]), 16'd3);
    wr(4'd1, 16'h0006);

    // R8 repeat transmit with count zero
    new_log();
    wr(4'd2, 16'd0);
    wr(4'd0, 16'h8605); settle(8);
    wr(4'd3, 16'h0051); wr(4'd3, 16'h0052); wr(4'd3, 16'h0053); settle(30);
    check("R8 repeat sends", 16'(nlog), 16'd4);
    check("R8 last byte", 16'(lbyte[3]), 16'h0053);
    rd(4'd1, v); check("R8 xrdy busy", v & 16'h1010, 16'h1010);
    rd(4'd2, v); check("R8 count ignored", v, 16'd0);
    wr(4'd0, 16'h8606); settle(12);
    check("R8 tx stop", 16'(lop[4]), 16'd3);
    rd(4'd1, v); check("R8 tx busy clear", v & 16'h1000, 16'h0000);

    // R8 repeat receive fills 4
    new_log();
    wr(4'd0, 16'h8405); settle(40);
    check("R8 recv total", 16'(nlog), 16'd5);
    check("R8 start read dir", 16'(lrd), 16'd1);
    check("R8 recv op", 16'(lop[4]), 16'd2);
    rd(4'd1, v); check("R8 rrdy", v & 16'h0008, 16'h0008);
    wr(4'd0, 16'h8406); settle(12);
    check("R8 rx stop", 16'(lop[5]), 16'd3);
    for (int i = 0; i < 4; i++) begin
      pop(v); check("R13 repeat rx order", v, 16'(8'hA0 + i));
    end
    settle(2);
    rd(4'd1, v); check("R13 rrdy cleared", v & 16'h0008, 16'h0000);

    // R13 counted receive
    new_log();
    wr(4'd2, 16'd3);
    wr(4'd0, 16'h8403); settle(40);
    check("R13 counted recv total", 16'(nlog), 16'd5);
    check("R5 rx stop op", 16'(lop[4]), 16'd3);
    rd(4'd1, v); check("R13 rrdy set", v & 16'h1008, 16'h0008);
    for (int i = 0; i < 3; i++) begin
      pop(v); check("R13 counted rx order", v, 16'(8'hA0 + i));
    end
    settle(2);
    rd(4'd1, v); check("R13 rrdy empty", v & 16'h0008, 16'h0000);

    finish_run();
  end
endmodule